// File: doc/BRIEF.md
# PCM Timeslot Drop/Insert Marker

This block rides alongside a framed PCM serial stream made of one framing bit followed by a run of fixed-width timeslots. It produces two per-bit strobes. The drop strobe follows the receive bit clock and flags the bit periods of selected receive timeslots. The insert strobe follows the transmit bit clock and flags the bit periods of selected transmit timeslots. While the insert strobe is high, the transmit serial output takes its bit from an alternate insert data input instead of the normal transmit data. The substitution happens within the same bit period and nothing is buffered.

Each side keeps its own frame position counter. A frame-sync pulse marks the framing bit and restarts that counter. If no pulse arrives, the counter wraps on its own after the last bit of the last timeslot. Each side also holds a selection mask with one bit for the framing bit and one bit for each timeslot. A write goes into a pending copy of the mask. The pending copy becomes the working mask at the next framing bit, so a slot is never marked for only part of its bits.

Top module: `pcm_dropins_marker`

## Requirements
- R1: `drop_ind` is high only in receive bit periods that belong to a position selected in the working drop mask, and is low in every other bit period.
- R2: For each selected timeslot, a strobe is high for exactly `SLOT_BITS` (default 8) consecutive bit periods, aligned with that timeslot's bits. It rises only on the first bit of the slot.
- R3: When mask bit 0 (the framing bit) is set, a strobe is high for exactly the single framing bit period, which is frame position 0.
- R4: Any combination of the framing bit and the timeslots can be selected at the same time. The drop mask and the insert mask are held separately, and a write to one leaves the other unchanged.
- R5: In every transmit bit period where `ins_ind` is high, `tx_out` equals `ins_data` of that same bit period.
- R6: In every transmit bit period where `ins_ind` is low, `tx_out` equals `tx_data`.
- R7: `ins_ind` follows the same selection rules as `drop_ind` (R1 to R3), using the insert mask and transmit timing.
- R8: A frame is 1 + `SLOTS`*`SLOT_BITS` bit periods long (default 193). A high frame-sync input in a bit period makes that period the framing bit, even in the middle of a frame. Without a sync pulse, the position after the last bit of the last timeslot is the framing bit.
- R9: Mask bit 0 selects the framing bit. Mask bit k (1 to `SLOTS`) selects timeslot k, which covers frame positions 1+`SLOT_BITS`*(k-1) through `SLOT_BITS`*k.
- R10: A mask written in any bit period other than the framing bit is first used at the next framing bit. A mask written during a framing bit period is first used at the framing bit after that one.
- R11: While reset is low, and after reset until a mask write takes effect, both masks are zero, both strobes are low and `tx_out` equals `tx_data`.
- R12: The receive side runs only on `rx_clk` and `rx_fsync`, and the transmit side runs only on `tx_clk` and `tx_fsync`. Each side keeps correct position while the other runs at an unrelated rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive bit clock |
| tx_clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| rx_fsync | input | 1 | High during the receive framing bit period |
| drop_wr | input | 1 | Write strobe for the drop mask (rx_clk domain) |
| drop_mask_wdata | input | SLOTS+1 | New drop mask value |
| drop_ind | output | 1 | Drop strobe, high on selected receive bit periods |
| tx_fsync | input | 1 | High during the transmit framing bit period |
| ins_wr | input | 1 | Write strobe for the insert mask (tx_clk domain) |
| ins_mask_wdata | input | SLOTS+1 | New insert mask value |
| tx_data | input | 1 | Normal transmit serial data |
| ins_data | input | 1 | Alternate insert serial data |
| ins_ind | output | 1 | Insert strobe, high on selected transmit bit periods |
| tx_out | output | 1 | Transmit serial output after substitution |

## Verification
The assertions assume that each frame-sync input is either high only once per frame or marks an intended early restart. They also assume that mask write data is steady in the cycle when its write strobe is sampled. The bench meets both conditions: it changes every input on the falling edge of the clock that owns it, and it raises frame sync only on the bit it treats as the framing bit. The bench keeps its own model of frame position and of the pending and working masks. It sweeps every bit of complete frames under several mask patterns, with writes at the framing bit, in the middle of a frame and just before the wrap, plus one early sync and one frame that wraps with no sync pulse. The receive and transmit threads run at the same time on clocks with different periods.

// File: rtl/pcm_mark_pkg.sv
package pcm_mark_pkg;

   localparam int DEF_SLOTS     = 24;
   localparam int DEF_SLOT_BITS = 8;

   // bits in one frame: framing bit plus all timeslot bits
   function automatic int frame_bits(input int slots, input int slot_bits);
      return 1 + slots * slot_bits;
   endfunction

   // width needed to index slot 0 (framing bit) through slot 'slots'
   function automatic int slot_idx_w(input int slots);
      return (slots < 1) ? 1 : $clog2(slots + 1);
   endfunction

endpackage

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos
   import pcm_mark_pkg::*;
#(
   parameter int SLOTS     = DEF_SLOTS,
   parameter int SLOT_BITS = DEF_SLOT_BITS,
   localparam int SW       = slot_idx_w(SLOTS),
   localparam int BW       = $clog2(SLOT_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fsync,
   output logic [SW-1:0] cur_slot,
   output logic [BW-1:0] cur_bit,
   output logic          frame_start
);

   if (SLOTS < 1) begin : g_bad_slots
      $error("pcm_frame_pos: SLOTS must be at least 1");
   end
   if (SLOT_BITS < 2) begin : g_bad_bits
      $error("pcm_frame_pos: SLOT_BITS must be at least 2");
   end

   localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS);
   localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_BITS - 1);

   logic [SW-1:0] slot_q, slot_d;
   logic [BW-1:0] bit_q,  bit_d;

   // position of the bit period now on the line; sync overrides the count
   always_comb begin
      cur_slot    = fsync ? '0 : slot_q;
      cur_bit     = fsync ? '0 : bit_q;
      frame_start = (cur_slot == '0);
   end

   // position of the following bit period
   always_comb begin
      slot_d = cur_slot;
      bit_d  = cur_bit + BW'(1);
      if (cur_slot == '0) begin
         slot_d = SW'(1);
         bit_d  = '0;
      end else if (cur_bit == LAST_BIT) begin
         bit_d  = '0;
         slot_d = (cur_slot == LAST_SLOT) ? '0 : cur_slot + SW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else begin
         slot_q <= slot_d;
         bit_q  <= bit_d;
      end
   end

   always_comb begin
      if (rst_n) begin
         assert_pos_legal_R8 : assert (slot_q <= LAST_SLOT && bit_q <= LAST_BIT &&
                                       (slot_q != '0 || bit_q == '0))
            else $error("frame position out of range");
      end
   end

   assert_wrap_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot == LAST_SLOT && cur_bit == LAST_BIT) |=> (cur_slot == '0))
      else $error("frame did not wrap to the framing bit");

endmodule

// File: rtl/pcm_mask_shadow.sv
module pcm_mask_shadow #(
   parameter int MW = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [MW-1:0] wdata,
   input  logic          frame_start,
   output logic [MW-1:0] eff_mask
);

   if (MW < 2) begin : g_bad_mw
      $error("pcm_mask_shadow: MW must be at least 2");
   end

   logic [MW-1:0] pend_q;
   logic [MW-1:0] act_q;

   // the framing bit already uses the value that becomes the working mask
   assign eff_mask = frame_start ? pend_q : act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (wr)          pend_q <= wdata;
         if (frame_start) act_q  <= pend_q;
      end
   end

   assert_mask_frame_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_q))
      else $error("working mask changed away from a framing bit");

endmodule

// File: rtl/pcm_slot_strobe.sv
module pcm_slot_strobe
   import pcm_mark_pkg::*;
#(
   parameter int SLOTS     = DEF_SLOTS,
   parameter int SLOT_BITS = DEF_SLOT_BITS,
   localparam int SW       = slot_idx_w(SLOTS),
   localparam int BW       = $clog2(SLOT_BITS),
   localparam int MW       = SLOTS + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [MW-1:0] mask,
   input  logic [SW-1:0] cur_slot,
   input  logic [BW-1:0] cur_bit,
   output logic          strobe
);

   logic [MW-1:0] hit;

   // one comparator per position; slot 0 is the single framing bit
   for (genvar i = 0; i < MW; i++) begin : g_dec
      assign hit[i] = mask[i] && (cur_slot == SW'(i));
   end

   assign strobe = |hit;

   assert_rise_aligned_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> (cur_bit == '0))
      else $error("strobe rose away from the first bit of a slot");

   assert_hold_in_slot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot != '0 && cur_bit != '0) |-> $stable(strobe))
      else $error("strobe changed inside a timeslot");

   assert_fbit_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot == '0 && strobe && !mask[1]) |=> (!strobe || cur_slot == '0))
      else $error("framing-bit strobe lasted longer than one bit");

endmodule

// File: rtl/pcm_side_marker.sv
module pcm_side_marker
   import pcm_mark_pkg::*;
#(
   parameter int SLOTS     = DEF_SLOTS,
   parameter int SLOT_BITS = DEF_SLOT_BITS,
   localparam int SW       = slot_idx_w(SLOTS),
   localparam int BW       = $clog2(SLOT_BITS),
   localparam int MW       = SLOTS + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fsync,
   input  logic          wr,
   input  logic [MW-1:0] wdata,
   output logic          strobe
);

   logic [SW-1:0] cur_slot;
   logic [BW-1:0] cur_bit;
   logic          frame_start;
   logic [MW-1:0] eff_mask;

   pcm_frame_pos #(
      .SLOTS     (SLOTS),
      .SLOT_BITS (SLOT_BITS)
   ) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsync       (fsync),
      .cur_slot    (cur_slot),
      .cur_bit     (cur_bit),
      .frame_start (frame_start)
   );

   pcm_mask_shadow #(
      .MW (MW)
   ) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (wr),
      .wdata       (wdata),
      .frame_start (frame_start),
      .eff_mask    (eff_mask)
   );

   pcm_slot_strobe #(
      .SLOTS     (SLOTS),
      .SLOT_BITS (SLOT_BITS)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask     (eff_mask),
      .cur_slot (cur_slot),
      .cur_bit  (cur_bit),
      .strobe   (strobe)
   );

endmodule

// File: rtl/pcm_dropins_marker.sv
module pcm_dropins_marker
   import pcm_mark_pkg::*;
#(
   parameter int SLOTS     = DEF_SLOTS,
   parameter int SLOT_BITS = DEF_SLOT_BITS,
   localparam int MW       = SLOTS + 1
) (
   input  logic          rx_clk,
   input  logic          tx_clk,
   input  logic          rst_n,
   input  logic          rx_fsync,
   input  logic          drop_wr,
   input  logic [MW-1:0] drop_mask_wdata,
   output logic          drop_ind,
   input  logic          tx_fsync,
   input  logic          ins_wr,
   input  logic [MW-1:0] ins_mask_wdata,
   input  logic          tx_data,
   input  logic          ins_data,
   output logic          ins_ind,
   output logic          tx_out
);

   // receive side: marks only, the receive data path is not touched here
   pcm_side_marker #(
      .SLOTS     (SLOTS),
      .SLOT_BITS (SLOT_BITS)
   ) u_rx_side (
      .clk    (rx_clk),
      .rst_n  (rst_n),
      .fsync  (rx_fsync),
      .wr     (drop_wr),
      .wdata  (drop_mask_wdata),
      .strobe (drop_ind)
   );

   // transmit side: the strobe also steers the per-bit data select
   pcm_side_marker #(
      .SLOTS     (SLOTS),
      .SLOT_BITS (SLOT_BITS)
   ) u_tx_side (
      .clk    (tx_clk),
      .rst_n  (rst_n),
      .fsync  (tx_fsync),
      .wr     (ins_wr),
      .wdata  (ins_mask_wdata),
      .strobe (ins_ind)
   );

   assign tx_out = ins_ind ? ins_data : tx_data;

   assert_reset_quiet_R11 : assert property (@(posedge tx_clk)
      !rst_n |-> (!ins_ind && tx_out == tx_data))
      else $error("transmit side not quiet during reset");

endmodule

// File: tb/tb_pcm_dropins_marker.sv
module tb_pcm_dropins_marker;

   localparam int RX_P   = 10;
   localparam int TX_P   = 14;
   localparam int SLOTS  = 24;
   localparam int SBITS  = 8;
   localparam int MW     = SLOTS + 1;
   localparam int FLEN   = 1 + SLOTS * SBITS;
   localparam int WD_LIM = 150000;

   logic          rx_clk = 1'b0;
   logic          tx_clk = 1'b0;
   logic          rst_n  = 1'b0;
   logic          rx_fsync = 1'b0;
   logic          drop_wr  = 1'b0;
   logic [MW-1:0] drop_mask_wdata = '0;
   logic          drop_ind;
   logic          tx_fsync = 1'b0;
   logic          ins_wr   = 1'b0;
   logic [MW-1:0] ins_mask_wdata = '0;
   logic          tx_data  = 1'b0;
   logic          ins_data = 1'b0;
   logic          ins_ind;
   logic          tx_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of each side
   int            rx_next = 0;
   logic [MW-1:0] rx_pend = '0, rx_act = '0;
   int            tx_next = 0;
   logic [MW-1:0] tx_pend = '0, tx_act = '0;

   pcm_dropins_marker #(.SLOTS(SLOTS), .SLOT_BITS(SBITS)) dut (
      .rx_clk          (rx_clk),
      .tx_clk          (tx_clk),
      .rst_n           (rst_n),
      .rx_fsync        (rx_fsync),
      .drop_wr         (drop_wr),
      .drop_mask_wdata (drop_mask_wdata),
      .drop_ind        (drop_ind),
      .tx_fsync        (tx_fsync),
      .ins_wr          (ins_wr),
      .ins_mask_wdata  (ins_mask_wdata),
      .tx_data         (tx_data),
      .ins_data        (ins_data),
      .ins_ind         (ins_ind),
      .tx_out          (tx_out)
   );

   always #(RX_P/2) rx_clk = ~rx_clk;
   always #(TX_P/2) tx_clk = ~tx_clk;

   // R9: bit 0 is the framing bit, bit k covers positions 1+8(k-1)..8k
   function automatic bit exp_mark(input logic [MW-1:0] m, input int pos);
      if (pos == 0) return m[0];
      return m[1 + (pos - 1) / SBITS];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp,
                        input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // one receive bit period; R1 R2 R3 R8 R10 checked against the model
   task automatic rx_bit(input bit fs, input bit wr, input logic [MW-1:0] wd);
      int pos;
      logic [MW-1:0] eff;
      bit e;
      @(negedge rx_clk);
      rx_fsync = fs; drop_wr = wr; drop_mask_wdata = wd;
      #(RX_P/4);
      pos = fs ? 0 : rx_next;
      eff = (pos == 0) ? rx_pend : rx_act;
      e   = exp_mark(eff, pos);
      check(drop_ind === e, (pos == 0) ? "R3" : "R2", int'(drop_ind), int'(e),
            $sformatf("R1 drop_ind pos %0d", pos));
      @(posedge rx_clk);
      if (pos == 0) rx_act = rx_pend;
      if (wr) rx_pend = wd;
      rx_next = (pos + 1) % FLEN;
   endtask

   // one transmit bit period; R5 R6 R7 with random serial data
   task automatic tx_bit(input bit fs, input bit wr, input logic [MW-1:0] wd);
      int pos;
      logic [MW-1:0] eff;
      bit e, d, a, o;
      @(negedge tx_clk);
      d = 1'($urandom); a = 1'($urandom);
      tx_fsync = fs; ins_wr = wr; ins_mask_wdata = wd; tx_data = d; ins_data = a;
      #(TX_P/4);
      pos = fs ? 0 : tx_next;
      eff = (pos == 0) ? tx_pend : tx_act;
      e   = exp_mark(eff, pos);
      o   = e ? a : d;
      check(ins_ind === e, "R7", int'(ins_ind), int'(e), $sformatf("ins_ind pos %0d", pos));
      check(tx_out === o, e ? "R5" : "R6", int'(tx_out), int'(o),
            $sformatf("tx_out pos %0d", pos));
      @(posedge tx_clk);
      if (pos == 0) tx_act = tx_pend;
      if (wr) tx_pend = wd;
      tx_next = (pos + 1) % FLEN;
   endtask

   task automatic rx_frame(input int n, input bit sync, input int wpos, input logic [MW-1:0] wd);
      for (int b = 0; b < n; b++) rx_bit(sync && b == 0, b == wpos, wd);
   endtask

   task automatic tx_frame(input int n, input bit sync, input int wpos, input logic [MW-1:0] wd);
      for (int b = 0; b < n; b++) tx_bit(sync && b == 0, b == wpos, wd);
   endtask

   task automatic rx_thread();
      rx_frame(FLEN, 1, 0, 25'h0000001);       // R10: write at framing bit, not yet used
      rx_frame(FLEN, 1, 5, 25'h1FFFFFE);       // R3: framing bit only
      rx_frame(FLEN, 1, FLEN-1, 25'h0AAAAAB);  // R2: every timeslot
      rx_frame(FLEN, 0, -1, '0);               // R4 mixed; R8 wrap without sync
      rx_frame(100, 1, 3, 25'h1000001);        // R8: frame cut short by early sync
      rx_frame(FLEN, 1, -1, '0);               // last slot plus framing bit
      rx_frame(FLEN, 1, 10, '0);
      rx_frame(FLEN, 1, -1, '0);               // cleared
   endtask

   task automatic tx_thread();
      tx_frame(FLEN, 1, 60, 25'h0000006);      // R10: mid-frame write waits
      tx_frame(FLEN, 1, 2, 25'h1555555);       // R7: slots 1 and 2
      tx_frame(FLEN, 1, -1, '0);               // R4: framing bit plus even slots
      tx_frame(FLEN, 0, 0, 25'h1FFFFFF);       // R8 wrap; write at framing bit
      tx_frame(FLEN, 1, -1, '0);               // R5: all positions inserted
      tx_frame(70, 1, 1, '0);                  // R8: early sync
      tx_frame(FLEN, 1, -1, '0);
      tx_frame(FLEN, 1, -1, '0);               // R6: pass-through again
   endtask

   initial begin
      #(WD_LIM * TX_P);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      tx_data = 1'b1; ins_data = 1'b0;
      #(2 * TX_P);
      // R11: quiet outputs under reset, both data polarities
      check(drop_ind === 1'b0, "R11", int'(drop_ind), 0, "drop_ind in reset");
      check(ins_ind === 1'b0, "R11", int'(ins_ind), 0, "ins_ind in reset");
      check(tx_out === 1'b1, "R11", int'(tx_out), 1, "tx_out in reset");
      tx_data = 1'b0; ins_data = 1'b1;
      #1;
      check(tx_out === 1'b0, "R11", int'(tx_out), 0, "tx_out follows tx_data in reset");
      @(negedge tx_clk);
      rst_n = 1'b1;
      repeat (3) @(posedge tx_clk);
      #1;
      check(drop_ind === 1'b0 && ins_ind === 1'b0, "R11", int'(drop_ind | ins_ind), 0,
            "strobes low after reset");
      // R12: both sides run together on unrelated clocks
      fork
         rx_thread();
         tx_thread();
      join
      done = 1'b1;
      report();
   end

endmodule